// File: doc/BRIEF.md
# Byte-Lane Parity Checker and Generator

This block sits on a 36-bit data port that is split into four 9-bit byte lanes, where the top bit of each lane is that lane's parity bit. It does two jobs. In its checking role it examines the data arriving at the port and drives an active-low error flag when any byte lane enabled by the bus-size logic fails parity. In its generating role it takes read data leaving the port and replaces the top bit of each lane with parity computed over the lower eight bits. A single odd/even select sets the parity sense for both jobs.

Read data comes from two places. Long words from storage pass through a dedicated generator and are then captured in an output register when a load strobe is seen. Mailbox words are sent to the output without being stored. A mailbox read with generation enabled borrows the port's one set of checking trees. While the trees are borrowed, the error flag is held inactive. Once the mailbox read ends, the output returns to the last stored long word, unchanged.

Top module: `parity_lane_unit`

## Requirements
- R1: While `rst` is high, the block sets `err_n` to 1 and `out_data` to all zeros at the next clock edge.
- R2: Lane k occupies bits 9k+8..9k, and bit 9k+8 is the parity bit. With `odd_sel`=0 (even parity), a lane passes when its nine bits hold an even number of ones. With `odd_sel`=1 (odd parity), it passes when that count is odd.
- R3: When `chk_en`=1 and no generating mailbox read is under way, `err_n` goes low one cycle later if at least one lane with `lane_mask[k]`=1 fails the check on `in_data`. Otherwise `err_n` is high.
- R4: A lane whose `lane_mask` bit is 0 never causes `err_n` to go low, whatever its data.
- R5: When `chk_en`=0, `err_n` is 1 on the following cycle.
- R6: When `rd_mbox`=1 and `gen_en`=1, `err_n` is 1 on the following cycle, whatever `in_data`, `lane_mask` and `chk_en` are.
- R7: When `rd_load`=1 and `rd_mbox`=0, `out_data` on the next cycle equals `rd_data`. If `gen_en`=1 on that edge, each bit 9k+8 is replaced by the parity of bits 9k+7..9k under the sense set by `odd_sel`, so that the whole lane passes R2.
- R8: `gen_en` and `odd_sel` have an effect on stored-word output only on a load edge. Changing them while no load takes place leaves `out_data` unchanged.
- R9: When `rd_mbox`=1, `out_data` on the next cycle equals `mbox_data`, with parity bits substituted as in R7 when `gen_en`=1.
- R10: A mailbox read does not disturb the stored long word. On the first cycle with `rd_mbox`=0 and `rd_load`=0 after the read, `out_data` again equals the last loaded word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst | input | 1 | Synchronous active-high reset |
| odd_sel | input | 1 | 1 = odd parity, 0 = even parity |
| gen_en | input | 1 | Parity generation enable for reads |
| chk_en | input | 1 | Input data on `in_data` is to be checked this cycle |
| lane_mask | input | 4 | Lanes valid for the current bus size |
| in_data | input | 36 | Incoming port data |
| rd_load | input | 1 | Load a new long word from storage |
| rd_data | input | 36 | Long word read from storage |
| rd_mbox | input | 1 | Mailbox read qualifier |
| mbox_data | input | 36 | Mailbox register contents |
| out_data | output | 36 | Registered outgoing port data |
| err_n | output | 1 | Registered active-low parity error flag |

## Verification
Every result appears exactly one clock edge after the inputs that cause it. `err_n` reflects the check on the inputs present at the previous edge. `out_data` reflects the load or mailbox selection made at that edge. The bench changes inputs on the falling edge and compares outputs on the following falling edge, so exactly one rising edge separates the stimulus from the sample. Hold-type checks (R8, R10) sample several successive falling edges with no load in between.

// File: rtl/plc_pkg.sv
package plc_pkg;
  typedef enum logic {
    TREE_CHECK = 1'b0,
    TREE_MBOX  = 1'b1
  } tree_owner_t;
endpackage

// File: rtl/parity_tree.sv
module parity_tree #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] d,
  output logic          x
);
  always_comb x = ^d;
endmodule

// File: rtl/err_flag_reg.sv
module err_flag_reg #(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             chk_en,
  input  logic             quiet,
  input  logic [LANES-1:0] lane_fail,
  input  logic [LANES-1:0] lane_mask,
  output logic             err_n
);
  logic any_fail;
  always_comb any_fail = |(lane_fail & lane_mask);

  always_ff @(posedge clk) begin
    if (rst)        err_n <= 1'b1;
    else if (quiet) err_n <= 1'b1;
    else            err_n <= ~(chk_en & any_fail);
  end

  a_r6_mbox_quiet: assert property (@(posedge clk) disable iff (rst)
    quiet |=> err_n);
  a_r5_idle_high: assert property (@(posedge clk) disable iff (rst)
    !chk_en |=> err_n);
  a_r4_masked_clean: assert property (@(posedge clk) disable iff (rst)
    (lane_mask == '0) |=> err_n);
endmodule

// File: rtl/out_stage.sv
module out_stage #(
  parameter int LANES = 4,
  parameter int DW    = 8,
  localparam int LW   = DW + 1,
  localparam int W    = LANES * LW
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         rd_load,
  input  logic [W-1:0] rd_data,
  input  logic         gen_en,
  input  logic         odd_sel,
  input  logic         rd_mbox,
  input  logic [W-1:0] mbox_word,
  output logic [W-1:0] out_data
);
  logic [W-1:0]     fifo_gen;
  logic [W-1:0]     fifo_hold;
  logic [LANES-1:0] fx;

  for (genvar l = 0; l < LANES; l++) begin : g_fifo_lane
    parity_tree #(.DW(DW)) u_tree (.d(rd_data[l*LW +: DW]), .x(fx[l]));
    always_comb begin
      fifo_gen[l*LW +: DW] = rd_data[l*LW +: DW];
      fifo_gen[l*LW + DW]  = gen_en ? (fx[l] ^ odd_sel) : rd_data[l*LW + DW];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          fifo_hold <= '0;
    else if (rd_load) fifo_hold <= fifo_gen;
  end

  always_ff @(posedge clk) begin
    if (rst)          out_data <= '0;
    else if (rd_mbox) out_data <= mbox_word;
    else if (rd_load) out_data <= fifo_gen;
    else              out_data <= fifo_hold;
  end

  a_r10_resume: assert property (@(posedge clk) disable iff (rst)
    (!rd_load && !rd_mbox) |=> (out_data == fifo_hold));
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    (!rd_load && !rd_mbox) ##1 (!rd_load && !rd_mbox) |=> $stable(out_data));

  for (genvar l = 0; l < LANES; l++) begin : g_chk
    a_r7_gen_parity: assert property (@(posedge clk) disable iff (rst)
      (rd_load && !rd_mbox && gen_en) |=>
        (($countones(out_data[l*LW +: LW]) % 2) == int'($past(odd_sel))));
  end
endmodule

// File: rtl/parity_lane_unit.sv
module parity_lane_unit #(
  parameter int LANES = 4,
  parameter int DW    = 8,
  localparam int LW   = DW + 1,
  localparam int W    = LANES * LW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             odd_sel,
  input  logic             gen_en,
  input  logic             chk_en,
  input  logic [LANES-1:0] lane_mask,
  input  logic [W-1:0]     in_data,
  input  logic             rd_load,
  input  logic [W-1:0]     rd_data,
  input  logic             rd_mbox,
  input  logic [W-1:0]     mbox_data,
  output logic [W-1:0]     out_data,
  output logic             err_n
);
  import plc_pkg::*;

  tree_owner_t      owner;
  logic [LANES-1:0] tx;
  logic [LANES-1:0] lane_fail;
  logic [W-1:0]     tree_src;
  logic [W-1:0]     mbox_word;

  always_comb owner = (rd_mbox && gen_en) ? TREE_MBOX : TREE_CHECK;

  // One shared tree per lane: checks in_data, or generates for mailbox output
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    always_comb tree_src[l*LW +: LW] = (owner == TREE_MBOX) ?
      mbox_data[l*LW +: LW] : in_data[l*LW +: LW];

    parity_tree #(.DW(DW)) u_tree (.d(tree_src[l*LW +: DW]), .x(tx[l]));

    always_comb begin
      lane_fail[l]          = tx[l] ^ in_data[l*LW + DW] ^ odd_sel;
      mbox_word[l*LW +: DW] = mbox_data[l*LW +: DW];
      mbox_word[l*LW + DW]  = (owner == TREE_MBOX) ? (tx[l] ^ odd_sel)
                                                   : mbox_data[l*LW + DW];
    end
  end

  err_flag_reg #(.LANES(LANES)) u_flag (
    .clk(clk), .rst(rst), .chk_en(chk_en), .quiet(owner == TREE_MBOX),
    .lane_fail(lane_fail), .lane_mask(lane_mask), .err_n(err_n)
  );

  out_stage #(.LANES(LANES), .DW(DW)) u_out (
    .clk(clk), .rst(rst), .rd_load(rd_load), .rd_data(rd_data),
    .gen_en(gen_en), .odd_sel(odd_sel), .rd_mbox(rd_mbox),
    .mbox_word(mbox_word), .out_data(out_data)
  );

  a_r1_reset_flag: assert property (@(posedge clk) rst |=> (err_n && out_data == '0));
  a_r9_mbox_raw: assert property (@(posedge clk) disable iff (rst)
    (rd_mbox && !gen_en) |=> (out_data == $past(mbox_data)));
endmodule

// File: tb/test_parity_lane_unit.sv
module test_parity_lane_unit;
  localparam int W = 36;
  logic clk = 0, rst = 1, odd_sel = 0, gen_en = 0, chk_en = 0, rd_load = 0, rd_mbox = 0;
  logic [3:0] lane_mask = 0;
  logic [W-1:0] in_data = 0, rd_data = 0, mbox_data = 0, out_data;
  logic err_n;
  int vecs = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  parity_lane_unit i_parity_lane_unit (
    .clk(clk), .rst(rst), .odd_sel(odd_sel), .gen_en(gen_en), .chk_en(chk_en),
    .lane_mask(lane_mask), .in_data(in_data), .rd_load(rd_load), .rd_data(rd_data),
    .rd_mbox(rd_mbox), .mbox_data(mbox_data), .out_data(out_data), .err_n(err_n)
  );

  function automatic logic fails(logic [8:0] ln, logic odd);
    return (($countones(ln) % 2) == 1) != odd;
  endfunction

  function automatic logic exp_err(logic [W-1:0] d, logic [3:0] m, logic odd);
    logic f = 0;
    for (int k = 0; k < 4; k++) if (m[k] && fails(d[k*9 +: 9], odd)) f = 1;
    return ~f;
  endfunction

  function automatic logic [W-1:0] gen(logic [W-1:0] d, logic odd);
    logic [W-1:0] r = d;
    for (int k = 0; k < 4; k++) r[k*9+8] = (($countones(d[k*9 +: 8]) % 2) == 1) ^ odd;
    return r;
  endfunction

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    vecs++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    chk_en = 0; rd_load = 0; rd_mbox = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [W-1:0] d, held;
    @(negedge clk); @(negedge clk);
    chk("R1 err_n", {35'd0, err_n}, 36'd1);
    chk("R1 out_data", out_data, '0);
    rst = 0;

    // R2 R3 R4: sweep masks, parity sense, data
    for (int i = 0; i < 400; i++) begin
      d = {$urandom, $urandom};
      for (int m = 0; m < 16; m++) begin
        for (int o = 0; o < 2; o++) begin
          @(negedge clk);
          idle(); chk_en = 1; in_data = d; lane_mask = 4'(m); odd_sel = 1'(o);
          @(negedge clk);
          chk("R3 R4 R2 check", {35'd0, err_n}, {35'd0, exp_err(d, 4'(m), 1'(o))});
        end
      end
    end
    // R2 single-bit corner: even-clean lane then one flipped bit
    @(negedge clk); idle(); chk_en = 1; odd_sel = 0; lane_mask = 4'b0100;
    in_data = gen(36'h0, 0) ^ (36'd1 << 20);
    @(negedge clk); chk("R2 one flipped bit", {35'd0, err_n}, 36'd0);

    // R5: errors present but chk_en low
    @(negedge clk); idle(); lane_mask = 4'hF; in_data = 36'h1; odd_sel = 0;
    @(negedge clk); chk("R5 idle", {35'd0, err_n}, 36'd1);

    // R6: generating mailbox read silences flag
    for (int i = 0; i < 50; i++) begin
      @(negedge clk); idle(); chk_en = 1; lane_mask = 4'hF; in_data = 36'h1 << (i % 36);
      rd_mbox = 1; gen_en = 1; odd_sel = 1'(i); mbox_data = {$urandom, $urandom};
      @(negedge clk);
      chk("R6 quiet", {35'd0, err_n}, 36'd1);
      chk("R9 mbox gen", out_data, gen(mbox_data, odd_sel));
    end
    // R9 raw mailbox, and flag still checks when not generating (R3)
    @(negedge clk); idle(); rd_mbox = 1; gen_en = 0; chk_en = 1; lane_mask = 4'h1;
    odd_sel = 0; in_data = 36'h1; mbox_data = 36'h9_8765_4321;
    @(negedge clk);
    chk("R9 mbox raw", out_data, 36'h9_8765_4321);
    chk("R3 check during raw mbox", {35'd0, err_n}, 36'd0);

    // R7: loads with and without generation
    for (int i = 0; i < 200; i++) begin
      @(negedge clk); idle(); rd_load = 1; rd_data = {$urandom, $urandom};
      gen_en = 1'(i >> 1); odd_sel = 1'(i);
      @(negedge clk);
      chk("R7 load", out_data, gen_en ? gen(rd_data, odd_sel) : rd_data);
    end

    // R8: selects toggled with no load
    @(negedge clk); idle(); rd_load = 1; rd_data = 36'h3_0F0F_0F0F; gen_en = 1; odd_sel = 0;
    held = gen(36'h3_0F0F_0F0F, 0);
    @(negedge clk); idle();
    chk("R7 load before hold", out_data, held);
    for (int i = 0; i < 8; i++) begin
      gen_en = 1'(i); odd_sel = 1'(i >> 1); rd_data = ~rd_data;
      @(negedge clk);
      chk("R8 hold", out_data, held);
    end

    // R10: mailbox read then resume
    rd_mbox = 1; gen_en = 1; odd_sel = 1; mbox_data = 36'hA_AAAA_5555;
    @(negedge clk);
    chk("R9 mbox over held", out_data, gen(36'hA_AAAA_5555, 1));
    idle();
    @(negedge clk);
    chk("R10 resume", out_data, held);

    // R1 again: reset mid-run
    rst = 1; @(negedge clk);
    chk("R1 reset out", out_data, '0);
    chk("R1 reset flag", {35'd0, err_n}, 36'd1);
    rst = 0;
    finish_run();
  end
endmodule